// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block sits inside a microcontroller power sequencer and decides whether the core must be woken. It watches four GPIO ports of 31 pins each, plus five peripheral wakeup sources: two USB line-state signals, the USB bus-supply detect, a DMA interrupt line and a pulse that marks the return from battery-backup mode. All asynchronous inputs pass through a two-flop synchronizer. A change in level in either direction then latches a sticky status flag.

Software reads and clears the flags over a simple synchronous register bus. A flag is cleared by writing one to its bit. Each status register has an enable register next to it. A flag that is set and enabled, and whose global gate is open where one applies, drives a single registered wakeup interrupt. That interrupt stays high until software clears the flag or removes the enable.

Top module: `wkup_event_ctrl`

## Requirements
- R1: After reset every register reads zero and `wake_irq_o` is low.
- R2: A GPIO status bit is set three clock edges after its pin changes level, on a rising change and on a falling change alike. GPIO port p (0..3) has its status register at byte address 0x04+8p, and pin k of that port sits at bit k.
- R3: Writing one to a status bit clears it. Writing zero leaves it as it is.
- R4: If a hardware event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R5: GPIO port p has its enable register at 0x08+8p. Bits 30:0 can be written. Bit 31 always reads zero.
- R6: A GPIO flag raises the interrupt only when its enable bit is set and `gpio_wk_en_i` is high.
- R7: The peripheral status register is at 0x30. Bits 1:0 are the two USB line states, bit 2 is the bus supply and bit 3 is the DMA line, each set on either edge. Bit 16 is set by a high cycle of `bb_exit_i`, which is sampled without a synchronizer.
- R8: The peripheral enable register is at 0x34. Only bits 3:0 can be written, and they map one to one onto status bits 3:0. Every other bit reads zero.
- R9: A USB line-state flag wakes only when its enable is set and `usb_wk_en_i` is high. The supply and DMA flags wake on their own enable alone. The battery-backup flag never raises the interrupt.
- R10: `wake_irq_o` is registered. It follows an enabled flag one edge later and holds until that flag is cleared or its enable or global gate is removed.
- R11: Reads of unmapped addresses return zero, and writes to them change no register.
- R12: Read data is captured on the clock edge that samples `reg_rd_i`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_pin_i | input | 124 | GPIO pin levels; port p pin k at index 31p+k |
| usb_ls_i | input | 2 | USB line-state levels |
| usb_vbus_i | input | 1 | USB bus-supply present |
| dma_irq_i | input | 1 | DMA interrupt line |
| bb_exit_i | input | 1 | Synchronous pulse on exit from battery backup |
| gpio_wk_en_i | input | 1 | Global GPIO wakeup gate |
| usb_wk_en_i | input | 1 | Global USB line-state wakeup gate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| wake_irq_o | output | 1 | Wakeup interrupt request |

## Verification
The embedded assertions check the flag bank on every cycle. A flag that gets a set is high on the next cycle, even when a clear hits it at the same time. A clear that meets no set drops its bit. A bit that sees neither keeps its value. The interrupt is also checked: it never rises unless some flag was set on the cycle before. The bench's scenarios are what show the rest: the three-edge latency through the synchronizer, the bit placement for each pin and source, the write masks on the enable registers, and how the two global gates are combined for each source type.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned GPIO_BASE    = 4;   // first port status address
  localparam int unsigned GPIO_STRIDE  = 8;   // status/enable pair per port
  localparam int unsigned PER_ST_ADDR  = 48;  // 0x30
  localparam int unsigned PER_EN_ADDR  = 52;  // 0x34
  localparam int unsigned PER_EDGE_W   = 4;   // ls[1:0], vbus, dma
  localparam int unsigned PER_FLAG_W   = 5;   // plus battery-backup exit
  localparam int unsigned BB_BUS_BIT   = 16;

  function automatic logic [ADDR_W-1:0] gpio_st_addr(input int unsigned p);
    return ADDR_W'(GPIO_BASE + p * GPIO_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] gpio_en_addr(input int unsigned p);
    return ADDR_W'(GPIO_BASE + p * GPIO_STRIDE + 4);
  endfunction
endpackage

// File: rtl/wkup_edge_det.sv
module wkup_edge_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ prev_q;
endmodule

// File: rtl/wkup_flag_bank.sv
module wkup_flag_bank #(
  parameter int unsigned W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0)); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_q)); // R3
endmodule

// File: rtl/wkup_event_ctrl.sv
module wkup_event_ctrl
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_PINS = 31
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*PORT_PINS-1:0] gpio_pin_i,
  input  logic [1:0]                     usb_ls_i,
  input  logic                           usb_vbus_i,
  input  logic                           dma_irq_i,
  input  logic                           bb_exit_i,
  input  logic                           gpio_wk_en_i,
  input  logic                           usb_wk_en_i,
  input  logic                           reg_wr_i,
  input  logic                           reg_rd_i,
  input  logic [7:0]                     reg_addr_i,
  input  logic [31:0]                    reg_wdata_i,
  output logic [31:0]                    reg_rdata_o,
  output logic                           wake_irq_o
);
  localparam int unsigned GPIO_W = NUM_PORTS * PORT_PINS;

  logic [GPIO_W-1:0]     gpio_edge;
  logic [PER_EDGE_W-1:0] per_edge;
  logic [PORT_PINS-1:0]  gflag  [NUM_PORTS];
  logic [PORT_PINS-1:0]  gen_q  [NUM_PORTS];
  logic [PORT_PINS-1:0]  gen_d  [NUM_PORTS];
  logic [PORT_PINS-1:0]  gclr   [NUM_PORTS];
  logic [PER_FLAG_W-1:0] pflag, pset, pclr;
  logic [PER_EDGE_W-1:0] pen_q, pen_d;
  logic [DATA_W-1:0]     rd_mux, rdata_q, rdata_d;
  logic                  irq_q, irq_d;
  logic                  gpio_hit, gpio_any;

  wkup_edge_det #(.W(GPIO_W)) u_gpio_edge (
    .clk(clk), .rst_n(rst_n), .raw_i(gpio_pin_i), .edge_o(gpio_edge));

  wkup_edge_det #(.W(PER_EDGE_W)) u_per_edge (
    .clk(clk), .rst_n(rst_n),
    .raw_i({dma_irq_i, usb_vbus_i, usb_ls_i}), .edge_o(per_edge));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] ST_A = gpio_st_addr(p);
    localparam logic [ADDR_W-1:0] EN_A = gpio_en_addr(p);

    always_comb begin
      gclr[p] = (reg_wr_i && reg_addr_i == ST_A) ? reg_wdata_i[PORT_PINS-1:0] : '0;
      gen_d[p] = gen_q[p];
      if (reg_wr_i && reg_addr_i == EN_A) gen_d[p] = reg_wdata_i[PORT_PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q[p] <= '0;
      else        gen_q[p] <= gen_d[p];
    end

    wkup_flag_bank #(.W(PORT_PINS)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_i(gpio_edge[p*PORT_PINS +: PORT_PINS]),
      .clr_i(gclr[p]), .flag_o(gflag[p]));
  end

  // Peripheral flags: [1:0] line state, [2] supply, [3] DMA, [4] backup exit.
  always_comb begin
    pset  = {bb_exit_i, per_edge};
    pclr  = '0;
    pen_d = pen_q;
    if (reg_wr_i && reg_addr_i == ADDR_W'(PER_ST_ADDR))
      pclr = {reg_wdata_i[BB_BUS_BIT], reg_wdata_i[PER_EDGE_W-1:0]};
    if (reg_wr_i && reg_addr_i == ADDR_W'(PER_EN_ADDR))
      pen_d = reg_wdata_i[PER_EDGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_q <= '0;
    else        pen_q <= pen_d;
  end

  wkup_flag_bank #(.W(PER_FLAG_W)) u_per_flags (
    .clk(clk), .rst_n(rst_n), .set_i(pset), .clr_i(pclr), .flag_o(pflag));

  // Read mux and interrupt combine
  always_comb begin
    rd_mux   = '0;
    gpio_hit = 1'b0;
    gpio_any = 1'b0;
    for (int unsigned p = 0; p < NUM_PORTS; p++) begin
      gpio_hit = gpio_hit | (|(gflag[p] & gen_q[p]));
      gpio_any = gpio_any | (|gflag[p]);
      if (reg_addr_i == gpio_st_addr(p)) rd_mux[PORT_PINS-1:0] = gflag[p];
      if (reg_addr_i == gpio_en_addr(p)) rd_mux[PORT_PINS-1:0] = gen_q[p];
    end
    if (reg_addr_i == ADDR_W'(PER_ST_ADDR)) begin
      rd_mux[PER_EDGE_W-1:0] = pflag[PER_EDGE_W-1:0];
      rd_mux[BB_BUS_BIT]     = pflag[PER_FLAG_W-1];
    end
    if (reg_addr_i == ADDR_W'(PER_EN_ADDR)) rd_mux[PER_EDGE_W-1:0] = pen_q;

    rdata_d = reg_rd_i ? rd_mux : rdata_q;
    irq_d   = (gpio_wk_en_i & gpio_hit)
            | (usb_wk_en_i & (|(pflag[1:0] & pen_q[1:0])))
            | (|(pflag[3:2] & pen_q[3:2]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign wake_irq_o  = irq_q;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |-> $past(gpio_any | (|pflag[PER_EDGE_W-1:0]))); // R10
  AST_IRQ_RESET_LOW: assert property (@(posedge clk)
    $rose(rst_n) |-> !wake_irq_o); // R1
endmodule

// File: tb/wkup_event_ctrl_bench.sv
module wkup_event_ctrl_bench;
  localparam int NP = 4;
  localparam int PP = 31;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP*PP-1:0]  gpio;
  logic [1:0]        usb_ls;
  logic              vbus, dma, bbx, ggen, ugen;
  logic              wr, rd;
  logic [7:0]        addr;
  logic [31:0]       wdata, rdata;
  logic              irq;
  int                n_chk = 0;
  int                n_bad = 0;
  logic [31:0]       got;

  always #4 clk = ~clk;

  wkup_event_ctrl u_wkup_event_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_pin_i(gpio), .usb_ls_i(usb_ls),
    .usb_vbus_i(vbus), .dma_irq_i(dma), .bb_exit_i(bbx),
    .gpio_wk_en_i(ggen), .usb_wk_en_i(ugen), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wake_irq_o(irq));

  // {port[1:0], pin[4:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 5'd0}, {2'd0, 5'd30}, {2'd1, 5'd7}, {2'd1, 5'd15},
    {2'd2, 5'd1}, {2'd2, 5'd22}, {2'd3, 5'd30}, {2'd3, 5'd12}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [7:0] st_a(input int p);
    return 8'(4 + 8 * p);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gpio = '0; usb_ls = '0; vbus = 0; dma = 0; bbx = 0;
    ggen = 0; ugen = 0; wr = 0; rd = 0; addr = '0; wdata = '0;
    wcyc(3); rst_n = 1'b1; wcyc(2);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 4; a <= 52; a += 4) begin
      bus_rd(8'(a), got);
      check("R1 reg", got, 32'd0);
    end

    // R2/R3 table walk: each pin latches on rise and on fall
    for (int i = 0; i < 8; i++) begin
      int p, k, o;
      p = int'(VEC[i][6:5]); k = int'(VEC[i][4:0]); o = (p + 1) % NP;
      @(negedge clk); gpio[p*PP + k] = 1'b1;
      wcyc(4);
      bus_rd(st_a(p), got);  check("R2 rise", got, 32'd1 << k);
      bus_rd(st_a(o), got);  check("R2 other port", got, 32'd0);
      bus_wr(st_a(p), 32'd1 << k);
      bus_rd(st_a(p), got);  check("R3 clear", got, 32'd0);
      @(negedge clk); gpio[p*PP + k] = 1'b0;
      wcyc(4);
      bus_rd(st_a(p), got);  check("R2 fall", got, 32'd1 << k);
      bus_wr(st_a(p), 32'hFFFF_FFFF);
    end

    // R3 write zero keeps flag
    @(negedge clk); gpio[3] = 1'b1; wcyc(4);
    bus_wr(8'h04, 32'd0);
    bus_rd(8'h04, got); check("R3 write zero", got, 32'h8);

    // R4 collision: second event meets clear in same cycle
    @(negedge clk); gpio[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr = 1'b1; addr = 8'h04; wdata = 32'h8;
    @(negedge clk); wr = 1'b0;
    bus_rd(8'h04, got); check("R4 set wins", got, 32'h8);
    bus_wr(8'h04, 32'h8);
    bus_rd(8'h04, got); check("R4 later clear", got, 32'h0);

    // R5 enable mask
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_rd(8'h08, got); check("R5 enable mask", got, 32'h7FFF_FFFF);
    bus_wr(8'h08, 32'h0);

    // R11 unmapped
    bus_wr(8'h3C, 32'hFFFF_FFFF);
    bus_rd(8'h3C, got); check("R11 unmapped", got, 32'h0);

    // R6 / R10 gpio wakeup gating (port 2 pin 5)
    @(negedge clk); gpio[2*PP + 5] = 1'b1; wcyc(4);
    bus_wr(8'h18, 32'h20); wcyc(3);
    check("R6 global off", {31'd0, irq}, 32'd0);
    ggen = 1'b1; wcyc(2);
    check("R6 both on", {31'd0, irq}, 32'd1);
    wcyc(5);
    check("R10 holds", {31'd0, irq}, 32'd1);
    bus_wr(8'h18, 32'h0); wcyc(2);
    check("R6 pin enable off", {31'd0, irq}, 32'd0);
    bus_wr(8'h18, 32'h20); wcyc(2);
    check("R10 re-enable", {31'd0, irq}, 32'd1);
    bus_wr(8'h14, 32'h20); wcyc(2);
    check("R10 cleared", {31'd0, irq}, 32'd0);
    bus_wr(8'h18, 32'h0); ggen = 1'b0;

    // R7 peripheral flags
    @(negedge clk); usb_ls[1] = 1'b1; vbus = 1'b1; dma = 1'b1; bbx = 1'b1;
    @(negedge clk); bbx = 1'b0;
    wcyc(4);
    bus_rd(8'h30, got); check("R7 flags", got, 32'h0001_000E);
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_rd(8'h30, got); check("R7 clear", got, 32'h0);
    @(negedge clk); vbus = 1'b0; wcyc(4);
    bus_rd(8'h30, got); check("R7 supply drop", got, 32'h4);
    bus_wr(8'h30, 32'h4);

    // R8 peripheral enable mask
    bus_wr(8'h34, 32'hFFFF_FFFF);
    bus_rd(8'h34, got); check("R8 enable mask", got, 32'hF);
    wcyc(2);
    check("R9 no flags", {31'd0, irq}, 32'd0);

    // R9 backup-exit flag alone never wakes
    @(negedge clk); bbx = 1'b1; @(negedge clk); bbx = 1'b0; wcyc(3);
    check("R9 backup no irq", {31'd0, irq}, 32'd0);
    bus_wr(8'h30, 32'h0001_0000);

    // R9 line state needs USB gate
    @(negedge clk); usb_ls[0] = 1'b1; wcyc(5);
    check("R9 usb gate off", {31'd0, irq}, 32'd0);
    ugen = 1'b1; wcyc(2);
    check("R9 usb gate on", {31'd0, irq}, 32'd1);
    ugen = 1'b0; bus_wr(8'h30, 32'h1); wcyc(2);

    // R9 DMA wakes without any global gate
    @(negedge clk); dma = 1'b0; wcyc(5);
    check("R9 dma ungated", {31'd0, irq}, 32'd1);

    // R12 read data holds without a new read
    bus_rd(8'h30, got);
    bus_wr(8'h30, 32'hF); wcyc(3);
    check("R12 read hold", rdata, 32'h8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule